// File: doc/BRIEF.md
# Fractional Clock Divider with Source Select

This block builds a general-purpose output clock from one of five source clocks. The sources are the fixed reference oscillator and four PLL channel outputs. The chosen source is divided by a rational ratio. The ratio has a 12-bit whole part and a 12-bit fraction counted in 1/4096 steps, so the average output frequency is f_src / (whole + frac/4096).

The fraction comes from a first-order phase accumulator. At the start of each output period the fraction is added to a 12-bit accumulator. When that add carries out, the period is one source cycle longer than the whole part; otherwise it equals the whole part. Each period is high for the first floor(N/2) of its N source cycles.

The design is a synchronous model. It runs on one system clock, and each source arrives as a one-cycle tick that marks a source edge. Software sets the source and the divisor only while the block is stopped. A busy flag shows when the divider is still finishing its last period. The block has no data stream, so every pin is a plain control or status pin with no back-pressure.

Top module: `frac_clkgen`

## Requirements
- R1: After reset, clk_out is 0, busy is 0, and every stored setting (source, whole part, fraction) is zero.
- R2: With a fraction of 0, every output period lasts exactly the effective whole part, counted in ticks of the selected source.
- R3: With a non-zero fraction, the accumulator starts at 0 when the block is enabled. Each period adds the fraction to it modulo 4096. A period whose add reaches 4096 or more lasts whole+1 ticks; every other period lasts whole ticks.
- R4: Over 4096 consecutive periods after enable, the total tick count equals 4096*whole + frac.
- R5: cfg_src picks the source: code i (0 to 4) uses src_tick[i]. Codes 5 to 7 pick no source, and the divider never starts.
- R6: An N-tick period drives clk_out high for its first floor(N/2) ticks and low for the rest. A rising edge happens only on a tick of the selected source.
- R7: cfg_wr loads source, whole part and fraction only in a cycle where the block is not enabled and not busy. A write in the same cycle that cfg_en rises is still accepted. Writes at any other time are ignored.
- R8: When cfg_en drops, busy stays 1 until the running period completes. busy then falls, and clk_out rests at 0 with no new period started.
- R9: A whole part of 1 acts as 2. A whole part of 0 keeps clk_out at 0 and busy at 0 even while enabled.
- R10: Disabling clears the accumulator, so re-enabling with the same settings repeats the same period sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Run request (registered inside the block) |
| cfg_wr | input | 1 | Write strobe for source and divisor settings |
| cfg_src | input | 3 | Source code to store |
| cfg_divi | input | 12 | Whole part of the divisor to store |
| cfg_divf | input | 12 | Fraction of the divisor in 1/4096 steps |
| src_tick | input | 5 | One-cycle edge ticks of the five sources |
| clk_out | output | 1 | Divided output clock |
| busy | output | 1 | High while an output period is in progress |

## Verification
Two events can fall in the same cycle: a settings write and the rise of the run request. The bench drives cfg_wr and cfg_en together and confirms from the measured period that the new whole part took effect. The other coincidence is a disable arriving while a period is still running. The bench drops cfg_en in mid-period and judges the result from the ports: busy must hold until the period has run its full expected length, and then no fresh rising edge may appear. Random settings over all five sources are compared, period by period and high time by high time, with an accumulator model held in the bench.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int FCG_DIV_W   = 12;
  localparam int FCG_FRAC_W  = 12;
  localparam int FCG_NUM_SRC = 5;

  typedef enum logic {
    FCG_IDLE = 1'b0,
    FCG_RUN  = 1'b1
  } fcg_state_e;
endpackage

// File: rtl/fcg_src_sel.sv
module fcg_src_sel #(
  parameter int NUM_SRC = 5,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               sel_tick
);
  logic [NUM_SRC-1:0] hit;

  // One gate per source; codes outside the source range match nothing.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/fcg_cfg_regs.sv
module fcg_cfg_regs #(
  parameter int SEL_W  = 3,
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_src,
  input  logic [DIV_W-1:0]  cfg_divi,
  input  logic [FRAC_W-1:0] cfg_divf,
  input  logic              busy,
  output logic              en_q,
  output logic [SEL_W-1:0]  src_q,
  output logic [DIV_W-1:0]  divi_q,
  output logic [FRAC_W-1:0] divf_q
);
  logic accept;

  // Settings are open for writing only when fully stopped.
  assign accept = cfg_wr && !en_q && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= '0;
      divi_q <= '0;
      divf_q <= '0;
    end else begin
      en_q <= cfg_en;
      if (accept) begin
        src_q  <= cfg_src;
        divi_q <= cfg_divi;
        divf_q <= cfg_divf;
      end
    end
  end
endmodule

// File: rtl/fcg_frac_acc.sv
module fcg_frac_acc #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] divf,
  output logic              carry,
  output logic [FRAC_W-1:0] acc_q
);
  logic [FRAC_W:0] sum;

  assign sum   = {1'b0, acc_q} + {1'b0, divf};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/fcg_period_ctr.sv
module fcg_period_ctr
  import fcg_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [DIV_W-1:0] divi,
  input  logic             carry,
  output logic             step,
  output logic             clear,
  output logic             busy,
  output logic             clk_out
);
  localparam int LEN_W = DIV_W + 1;

  fcg_state_e       st_q;
  logic [LEN_W-1:0] cnt_q, len_q, hi_q, next_len;
  logic [DIV_W-1:0] divi_eff;
  logic             running, can_run, start, wrap;

  assign divi_eff = (divi < DIV_W'(2)) ? DIV_W'(2) : divi;
  assign next_len = {1'b0, divi_eff} + LEN_W'(carry);
  assign can_run  = |divi;
  assign running  = (st_q == FCG_RUN);
  assign start    = !running && en && can_run && tick;
  assign wrap     = running && tick && (cnt_q == len_q - 1'b1);
  assign step     = start || (wrap && en);
  assign clear    = !running && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FCG_IDLE;
      cnt_q <= '0;
      len_q <= '0;
      hi_q  <= '0;
    end else if (step) begin
      st_q  <= FCG_RUN;
      cnt_q <= '0;
      len_q <= next_len;
      hi_q  <= next_len >> 1;
    end else if (wrap) begin
      st_q  <= FCG_IDLE;
      cnt_q <= '0;
    end else if (running && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy    = running;
  assign clk_out = running && (cnt_q < hi_q);
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
  import fcg_pkg::*;
#(
  parameter int NUM_SRC = FCG_NUM_SRC,
  parameter int DIV_W   = FCG_DIV_W,
  parameter int FRAC_W  = FCG_FRAC_W,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_src,
  input  logic [DIV_W-1:0]   cfg_divi,
  input  logic [FRAC_W-1:0]  cfg_divf,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               clk_out,
  output logic               busy
);
  logic              en_q, sel_tick, step, clear, carry;
  logic [SEL_W-1:0]  src_q;
  logic [DIV_W-1:0]  divi_q;
  logic [FRAC_W-1:0] divf_q, acc_q;

  fcg_cfg_regs #(.SEL_W(SEL_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_src(cfg_src), .cfg_divi(cfg_divi), .cfg_divf(cfg_divf),
    .busy(busy), .en_q(en_q), .src_q(src_q), .divi_q(divi_q), .divf_q(divf_q)
  );

  fcg_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .sel(src_q), .src_tick(src_tick), .sel_tick(sel_tick)
  );

  fcg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .divf(divf_q), .carry(carry), .acc_q(acc_q)
  );

  fcg_period_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick), .en(en_q), .divi(divi_q),
    .carry(carry), .step(step), .clear(clear), .busy(busy), .clk_out(clk_out)
  );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
  parameter int SEL_W  = 3,
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              busy,
  input logic              clk_out,
  input logic              sel_tick,
  input logic              carry,
  input logic [SEL_W-1:0]  src_q,
  input logic [DIV_W-1:0]  divi_q,
  input logic [FRAC_W-1:0] divf_q,
  input logic [FRAC_W-1:0] acc_q
);
  a_r8_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !clk_out);

  a_r8_no_new_period: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en_q) |=> !$rose(clk_out));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q || busy) |=> ($stable(divi_q) && $stable(divf_q) && $stable(src_q)));

  a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (divi_q == '0 && !busy) |=> !busy);

  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(sel_tick));

  a_r10_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy && !en_q) |-> (acc_q == '0));

  a_r2_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (divf_q == '0 && busy) |-> !carry);
endmodule

bind frac_clkgen fcg_checker #(.SEL_W(SEL_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_fcg_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .busy(busy), .clk_out(clk_out),
  .sel_tick(sel_tick), .carry(carry), .src_q(src_q), .divi_q(divi_q),
  .divf_q(divf_q), .acc_q(acc_q)
);

// File: tb/test_frac_clkgen.sv
module test_frac_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_wr = 1'b0;
  logic [2:0]  cfg_src = '0;
  logic [11:0] cfg_divi = '0, cfg_divf = '0;
  logic [4:0]  src_tick = '0;
  logic        clk_out, busy;

  frac_clkgen i_frac_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
    .cfg_src(cfg_src), .cfg_divi(cfg_divi), .cfg_divf(cfg_divf),
    .src_tick(src_tick), .clk_out(clk_out), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // Measurement state, updated at the falling edge.
  int ncyc = 0, src_now = 0;
  int since = 0, csince = 0, hi_acc = 0;
  int per_ticks = 0, per_clks = 0, per_hi = 0, rises = 0;
  bit prev_out = 1'b0, saw_high = 1'b0;

  always @(negedge clk) begin
    if (clk_out && !prev_out) begin
      per_ticks = since; per_clks = csince; per_hi = hi_acc;
      since = 0; csince = 0; hi_acc = 0;
      rises++;
    end
    if (clk_out) saw_high = 1'b1;
    prev_out = clk_out;
    for (int i = 0; i < 5; i++) src_tick[i] = ((ncyc % (i + 1)) == 0);
    if (src_now < 5 && src_tick[src_now]) begin
      since++;
      if (clk_out) hi_acc++;
    end
    csince++;
    ncyc++;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Bench model of the period sequence.
  int m_acc = 0, m_divi = 2, m_divf = 0;
  function automatic int next_len();
    int s, d;
    s = m_acc + m_divf;
    m_acc = s % 4096;
    d = (m_divi < 2) ? 2 : m_divi;
    return d + ((s >= 4096) ? 1 : 0);
  endfunction

  task automatic wait_rise();
    int r0 = rises;
    wait (rises != r0);
    #1;
  endtask

  task automatic program_cfg(int src, int divi, int divf, bit with_en);
    @(negedge clk);
    cfg_src = 3'(src); cfg_divi = 12'(divi); cfg_divf = 12'(divf);
    cfg_wr = 1'b1;
    if (with_en) cfg_en = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic stop_all();
    @(negedge clk);
    cfg_en = 1'b0;
    wait (!busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic start_run(int src, int divi, int divf);
    stop_all();
    src_now = src; m_divi = divi; m_divf = divf; m_acc = 0;
    program_cfg(src, divi, divf, 1'b0);
    @(negedge clk);
    cfg_en = 1'b1;
  endtask

  // Compares n completed periods (length and high time) with the model.
  task automatic run_seq(string tag, int n);
    int e;
    m_acc = 0;
    wait_rise();
    e = next_len();
    for (int k = 0; k < n; k++) begin
      wait_rise();
      check({tag, " period"}, per_ticks, e);
      check("R6 high time", per_hi, e / 2);
      e = next_len();
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int total, e, sd, rs, rd, rf;
    sd = $urandom(32'd20240517);
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 clk_out", int'(clk_out), 0);
    check("R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);

    // R2: pure integer division
    start_run(0, 5, 0);
    run_seq("R2", 8);

    // R3: fractional alternation
    start_run(0, 4, 2048);
    run_seq("R3", 10);
    start_run(1, 3, 3000);
    run_seq("R3", 12);

    // R4: long-run average over 4096 periods
    start_run(0, 3, 1234);
    wait_rise();
    total = 0;
    for (int k = 0; k < 4096; k++) begin
      wait_rise();
      total += per_ticks;
    end
    check("R4 total ticks", total, 4096 * 3 + 1234);

    // R5: source select measured in system clocks
    start_run(2, 4, 0);
    wait_rise(); wait_rise();
    check("R5 src2 clocks", per_clks, 12);
    start_run(4, 3, 0);
    wait_rise(); wait_rise();
    check("R5 src4 clocks", per_clks, 15);
    start_run(5, 4, 0);
    repeat (60) @(negedge clk);
    check("R5 no source busy", int'(busy), 0);

    // R9: whole part of 0 holds low, 1 acts as 2
    start_run(0, 0, 0);
    saw_high = 1'b0;
    repeat (60) @(negedge clk);
    check("R9 zero busy", int'(busy), 0);
    check("R9 zero output", int'(saw_high), 0);
    start_run(0, 1, 0);
    run_seq("R9", 4);

    // R7: writes while enabled are ignored
    start_run(0, 6, 0);
    wait_rise();
    program_cfg(0, 9, 100, 1'b1);
    wait_rise(); wait_rise();
    check("R7 ignored write", per_ticks, 6);
    // R7: write together with enable rise is accepted
    stop_all();
    src_now = 0;
    program_cfg(0, 7, 0, 1'b1);
    wait_rise(); wait_rise();
    check("R7 write with enable", per_ticks, 7);

    // R8: disable mid-period, busy holds until the period ends
    start_run(0, 10, 0);
    wait_rise();
    repeat (3) @(negedge clk);
    cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 busy holds", int'(busy), 1);
    wait (!busy);
    #1;
    check("R8 full last period", since, 10);
    saw_high = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 output rests low", int'(saw_high), 0);
    check("R8 busy low", int'(busy), 0);

    // R10: re-enable repeats the sequence from a cleared accumulator
    start_run(0, 3, 1500);
    run_seq("R10 first", 5);
    stop_all();
    @(negedge clk);
    cfg_en = 1'b1;
    run_seq("R10 repeat", 5);

    // Constrained random settings checked against the model (R3, R6)
    for (int it = 0; it < 6; it++) begin
      rs = $urandom_range(4, 0);
      rd = $urandom_range(20, 2);
      rf = $urandom_range(4095, 0);
      start_run(rs, rd, rf);
      run_seq("R3 random", 20);
    end

    stop_all();
    e = sd;
    summary();
  end
endmodule